// File: doc/BRIEF.md
# ADPCM Streaming Sample Accelerator

This block feeds a processor with audio samples that sit in a byte-addressed external memory. Software writes three 32-bit positions into the block: where the stream starts, where it ends, and where the next sample comes from. It then picks a sample format, and for compressed audio it also loads a table of predictor coefficients. After that, every pulse on `smp_req` makes the block fetch the bytes that one sample needs and decode them. The sample comes back on `smp_data` with a one-cycle `smp_valid` strobe. The block then moves the position on, and when the position reaches the end of the buffer it jumps back to the start.

Two formats are decoded. The compressed format is 4-bit ADPCM. Data is grouped in frames of 16 nibbles, and each frame opens with a one-byte header that gives a scale shift and a coefficient-pair index. Each sample comes from a second-order prediction on the two previous outputs, plus a scaled residual nibble. The plain format is 16-bit PCM stored high byte first. Both formats keep the two most recent outputs as history, and software can read or preload that history through the register port.

Top module: `adpcm_stream_accel`

## Requirements
- R1: After a synchronous active-low reset, every register below reads 0. `busy`, `mem_req` and `smp_valid` are low, and `smp_data` is 0.
- R2: Register port. Each write is one cycle with `reg_wr_en`, and reads are combinational on `reg_rdata`. Index map: 0/1 current position high/low, 2/3 start high/low, 4/5 end high/low, 6 format, 7 frame header (low 8 bits), 8 history yn1, 9 history yn2, 10 status (bit 0 = unknown-format flag, read only), 16+k coefficient k for k = 0..15. Writes are ignored while `busy` is high.
- R3: ADPCM (format 0x0000), header. If the position's low 4 bits are zero when a sample is requested, the block first reads the byte at (position with low 4 bits cleared) >> 1 into the header register and adds 2 to the position.
- R4: ADPCM nibble. The data byte is read at position >> 1. An even position uses bits 7:4 and an odd position uses bits 3:0. The nibble is a signed 4-bit value (8..15 mean -8..-1).
- R5: ADPCM value = (nibble << header[3:0]) + ((0x400 + c1*yn1 + c2*yn2) >>> 11). The pair is c1 = coefficient 2p and c2 = coefficient 2p+1, where p = header[6:4]. All operands are signed 16-bit.
- R6: The ADPCM result saturates to +0x7FFF and -0x7FFF. It never produces 0x8000.
- R7: After a decoded sample, yn2 takes the old yn1 and yn1 takes the new sample. In ADPCM the position then advances by 1.
- R8: PCM (format 0x000A). The position is a byte address. The sample is {byte[pos], byte[pos+1]}, the position advances by 2, and the history updates as in R7.
- R9: After every sample, if the advanced position is greater than or equal to the end (unsigned), the position reloads from the start.
- R10: A request accepted while idle raises `busy` on the next cycle. `busy` stays high until the cycle in which `smp_valid` pulses. A request made while busy is ignored. `mem_req` holds `mem_addr` steady until a cycle in which `mem_rvalid` delivers `mem_rdata`.
- R11: Any other format code is decoded as PCM but leaves the history unchanged. It sets the status flag, which stays set until the format register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| smp_req | input | 1 | Request one sample |
| busy | output | 1 | A sample is being fetched or decoded |
| smp_valid | output | 1 | One-cycle strobe: `smp_data` holds a new sample |
| smp_data | output | 16 | Decoded sample |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rvalid | input | 1 | Memory returns the requested byte this cycle |
| mem_rdata | input | 8 | Returned byte |

## Verification
The bench targets frame boundaries. A design that misses a header fetch there, or fetches it at the wrong byte, decodes the whole frame with a stale scale and the wrong coefficient pair. It also drives both saturation rails on purpose. A design that clamps the negative side at 0x8000, or that wraps instead of clamping, returns a value one off or of the wrong sign. Wrap-around is tested in both formats, where an off-by-one compare skips the last sample or reads past the end. Further cases cover requests and register writes made while busy, which a careless design would serve twice or let corrupt the history, and an unknown format, which must leave the history unchanged while raising the flag.

// File: rtl/adpcm_accel_pkg.sv
// Shared types and constants for the streaming sample accelerator.
// Assumes a 5-bit register index space with coefficients in the upper half.
package adpcm_accel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PCM_HI,
        ST_PCM_LO,
        ST_CALC
    } acc_state_e;

    localparam logic [15:0] FMT_ADPCM = 16'h0000;
    localparam logic [15:0] FMT_PCM16 = 16'h000A;

    localparam logic [3:0] RG_CUR_HI   = 4'd0;
    localparam logic [3:0] RG_CUR_LO   = 4'd1;
    localparam logic [3:0] RG_START_HI = 4'd2;
    localparam logic [3:0] RG_START_LO = 4'd3;
    localparam logic [3:0] RG_END_HI   = 4'd4;
    localparam logic [3:0] RG_END_LO   = 4'd5;
    localparam logic [3:0] RG_FORMAT   = 4'd6;
    localparam logic [3:0] RG_HEADER   = 4'd7;
    localparam logic [3:0] RG_YN1      = 4'd8;
    localparam logic [3:0] RG_YN2      = 4'd9;
    localparam logic [3:0] RG_STATUS   = 4'd10;

endpackage

// File: rtl/adpcm_predictor.sv
// Second-order ADPCM reconstruction: scaled residual plus rounded
// fixed-point prediction from two history samples, clamped symmetrically.
// Assumes a 4-bit signed residual and FRAC-bit fractional coefficients.
module adpcm_predictor #(
    parameter int W    = 16,
    parameter int FRAC = 11
) (
    input  logic [3:0]          code,
    input  logic [3:0]          shift,
    input  logic signed [W-1:0] c1,
    input  logic signed [W-1:0] c2,
    input  logic signed [W-1:0] y1,
    input  logic signed [W-1:0] y2,
    output logic signed [W-1:0] sample
);
    localparam int AW = 2 * W + 2;
    localparam int SW = W + 5;
    localparam logic signed [W-1:0] LIM = {1'b0, {(W-1){1'b1}}};

    logic signed [2*W-1:0] p1, p2;
    logic signed [AW-1:0]  acc, pred;
    logic signed [SW-1:0]  step;
    logic signed [AW:0]    total;

    // Form prediction, residual and clamped sum.
    always_comb begin
        p1    = c1 * y1;
        p2    = c2 * y2;
        acc   = AW'(p1) + AW'(p2) + AW'(1 <<< (FRAC - 1));
        pred  = acc >>> FRAC;
        step  = SW'($signed(code)) <<< shift;
        total = (AW+1)'(pred) + (AW+1)'(step);
        if (total > (AW+1)'(LIM))
            sample = LIM;
        else if (total < -((AW+1)'(LIM)))
            sample = -LIM;
        else
            sample = total[W-1:0];
    end
endmodule

// File: rtl/adpcm_coef_bank.sv
// Register bank of signed predictor coefficients, arranged as pairs.
// Provides one pair to the decoder and one word to the readback mux.
module adpcm_coef_bank #(
    parameter int N_PAIRS = 8,
    parameter int W       = 16,
    localparam int N_COEF = 2 * N_PAIRS,
    localparam int IDX_W  = $clog2(N_COEF),
    localparam int SEL_W  = $clog2(N_PAIRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [SEL_W-1:0] pair_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     c1,
    output logic [W-1:0]     c2,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] coef_q [N_COEF];

    for (genvar g = 0; g < N_COEF; g++) begin : g_coef
        // Hold one coefficient word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                coef_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                coef_q[g] <= wr_data;
        end
    end

    // Select the active pair and the readback word.
    always_comb begin
        c1      = coef_q[{pair_sel, 1'b0}];
        c2      = coef_q[{pair_sel, 1'b1}];
        rd_data = coef_q[rd_idx];
    end
endmodule

// File: rtl/accel_addr_step.sv
// Advances the stream position and reloads the start on reaching the end.
module accel_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    inc,
    input  logic [AW-1:0] start_a,
    input  logic [AW-1:0] end_a,
    output logic [AW-1:0] next
);
    logic [AW-1:0] sum;

    // Add the step, then compare against the end (unsigned).
    always_comb begin
        sum  = cur + AW'(inc);
        next = (sum >= end_a) ? start_a : sum;
    end
endmodule

// File: rtl/adpcm_stream_accel.sv
// Streaming sample accelerator top: register file, fetch sequencer and
// decode write-back. Assumes one byte per memory handshake; register
// writes are honoured only while idle.
module adpcm_stream_accel
    import adpcm_accel_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int COEF_PAIRS = 8,
    parameter int FRAC       = 11,
    localparam int DW        = 16,
    localparam int HW        = ADDR_W / 2,
    localparam int CIDX_W    = $clog2(2 * COEF_PAIRS),
    localparam int SEL_W     = $clog2(COEF_PAIRS),
    localparam int REG_AW    = CIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              smp_req,
    output logic              busy,
    output logic              smp_valid,
    output logic [DW-1:0]     smp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata
);
    acc_state_e state_q;
    logic [ADDR_W-1:0] cur_q, start_q, end_q, next_pos;
    logic [DW-1:0]     fmt_q, yn1_q, yn2_q, coef_rd, c1, c2;
    logic [7:0]        hdr_q, byte_hi_q, byte_lo_q;
    logic              err_q;
    logic signed [DW-1:0] adpcm_val;
    logic [DW-1:0]     sample_val;
    logic              is_adpcm, is_pcm, take_byte, reg_we, unused_hdr;
    logic [2:0]        step_inc;
    logic [3:0]        nib;

    assign is_adpcm   = (fmt_q == FMT_ADPCM);
    assign is_pcm     = (fmt_q == FMT_PCM16);
    assign busy       = (state_q != ST_IDLE);
    assign take_byte  = mem_req && mem_rvalid;
    assign reg_we     = reg_wr_en && !busy;
    assign unused_hdr = hdr_q[7];

    adpcm_coef_bank #(.N_PAIRS(COEF_PAIRS), .W(DW)) coef_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we && reg_addr[REG_AW-1]),
        .wr_idx  (reg_addr[CIDX_W-1:0]),
        .wr_data (reg_wdata),
        .pair_sel(hdr_q[4 +: SEL_W]),
        .rd_idx  (reg_addr[CIDX_W-1:0]),
        .c1      (c1),
        .c2      (c2),
        .rd_data (coef_rd)
    );

    adpcm_predictor #(.W(DW), .FRAC(FRAC)) pred_i (
        .code  (nib),
        .shift (hdr_q[3:0]),
        .c1    (c1),
        .c2    (c2),
        .y1    (yn1_q),
        .y2    (yn2_q),
        .sample(adpcm_val)
    );

    accel_addr_step #(.AW(ADDR_W)) step_i (
        .cur    (cur_q),
        .inc    (step_inc),
        .start_a(start_q),
        .end_a  (end_q),
        .next   (next_pos)
    );

    // Choose the nibble, the sample value and the position step.
    always_comb begin
        nib        = cur_q[0] ? byte_lo_q[3:0] : byte_lo_q[7:4];
        sample_val = is_adpcm ? adpcm_val : {byte_hi_q, byte_lo_q};
        step_inc   = is_adpcm ? 3'd1 : 3'd2;
    end

    // Drive the memory request for the byte the current state needs.
    always_comb begin
        mem_req  = 1'b1;
        mem_addr = '0;
        unique case (state_q)
            ST_HDR:    mem_addr = {1'b0, cur_q[ADDR_W-1:4], 3'b000};
            ST_DATA:   mem_addr = {1'b0, cur_q[ADDR_W-1:1]};
            ST_PCM_HI: mem_addr = cur_q;
            ST_PCM_LO: mem_addr = cur_q + ADDR_W'(1);
            default:   mem_req  = 1'b0;
        endcase
    end

    // Sequence fetches, decode write-back and register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            start_q   <= '0;
            end_q     <= '0;
            fmt_q     <= '0;
            hdr_q     <= '0;
            yn1_q     <= '0;
            yn2_q     <= '0;
            err_q     <= 1'b0;
            byte_hi_q <= '0;
            byte_lo_q <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (smp_req) begin
                        if (!is_adpcm)
                            state_q <= ST_PCM_HI;
                        else if (cur_q[3:0] == 4'd0)
                            state_q <= ST_HDR;
                        else
                            state_q <= ST_DATA;
                    end
                    if (reg_we && !reg_addr[REG_AW-1]) begin
                        unique case (reg_addr[3:0])
                            RG_CUR_HI:   cur_q[ADDR_W-1:HW] <= reg_wdata;
                            RG_CUR_LO:   cur_q[HW-1:0]      <= reg_wdata;
                            RG_START_HI: start_q[ADDR_W-1:HW] <= reg_wdata;
                            RG_START_LO: start_q[HW-1:0]      <= reg_wdata;
                            RG_END_HI:   end_q[ADDR_W-1:HW] <= reg_wdata;
                            RG_END_LO:   end_q[HW-1:0]      <= reg_wdata;
                            RG_FORMAT: begin
                                fmt_q <= reg_wdata;
                                err_q <= 1'b0;
                            end
                            RG_HEADER:   hdr_q <= reg_wdata[7:0];
                            RG_YN1:      yn1_q <= reg_wdata;
                            RG_YN2:      yn2_q <= reg_wdata;
                            default: ;
                        endcase
                    end
                end
                ST_HDR: if (take_byte) begin
                    hdr_q   <= mem_rdata;
                    cur_q   <= cur_q + ADDR_W'(2);
                    state_q <= ST_DATA;
                end
                ST_DATA: if (take_byte) begin
                    byte_lo_q <= mem_rdata;
                    state_q   <= ST_CALC;
                end
                ST_PCM_HI: if (take_byte) begin
                    byte_hi_q <= mem_rdata;
                    state_q   <= ST_PCM_LO;
                end
                ST_PCM_LO: if (take_byte) begin
                    byte_lo_q <= mem_rdata;
                    state_q   <= ST_CALC;
                end
                ST_CALC: begin
                    smp_data  <= sample_val;
                    smp_valid <= 1'b1;
                    cur_q     <= next_pos;
                    if (is_adpcm || is_pcm) begin
                        yn2_q <= yn1_q;
                        yn1_q <= sample_val;
                    end else begin
                        err_q <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Combinational register readback.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[REG_AW-1]) begin
            reg_rdata = coef_rd;
        end else begin
            unique case (reg_addr[3:0])
                RG_CUR_HI:   reg_rdata = cur_q[ADDR_W-1:HW];
                RG_CUR_LO:   reg_rdata = cur_q[HW-1:0];
                RG_START_HI: reg_rdata = start_q[ADDR_W-1:HW];
                RG_START_LO: reg_rdata = start_q[HW-1:0];
                RG_END_HI:   reg_rdata = end_q[ADDR_W-1:HW];
                RG_END_LO:   reg_rdata = end_q[HW-1:0];
                RG_FORMAT:   reg_rdata = fmt_q;
                RG_HEADER:   reg_rdata = {8'h00, hdr_q};
                RG_YN1:      reg_rdata = yn1_q;
                RG_YN2:      reg_rdata = yn2_q;
                RG_STATUS:   reg_rdata = {15'd0, err_q};
                default:     reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adpcm_stream_accel_chk.sv
// Protocol and range checks for the accelerator, attached through bind.
module adpcm_stream_accel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_req,
    input logic              busy,
    input logic              smp_valid,
    input logic [15:0]       smp_data,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [15:0]       fmt,
    input logic [ADDR_W-1:0] cur_pos,
    input logic [ADDR_W-1:0] start_pos,
    input logic [ADDR_W-1:0] end_pos
);
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    a_r10_idle_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && smp_req |=> busy);

    a_r10_valid_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !busy && $past(busy));

    a_r6_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && fmt == 16'h0000 |-> smp_data != 16'h8000);

    a_r9_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (cur_pos < end_pos) || (cur_pos == start_pos));
endmodule

bind adpcm_stream_accel adpcm_stream_accel_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_req   (smp_req),
    .busy      (busy),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .fmt       (fmt_q),
    .cur_pos   (cur_q),
    .start_pos (start_q),
    .end_pos   (end_q)
);

// File: tb/adpcm_stream_accel_tb.sv
`timescale 1ns/1ps
module adpcm_stream_accel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        smp_req = 1'b0;
    logic        busy, smp_valid, mem_req;
    logic [15:0] smp_data;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int vcount = 0;
    bit done = 1'b0;

    logic [7:0]  mem [256];
    logic [31:0] m_cur, m_start, m_end;
    logic [15:0] m_fmt, m_y1, m_y2;
    logic [7:0]  m_hdr;
    logic        m_err;
    logic [15:0] m_coef [16];

    adpcm_stream_accel dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_req(smp_req),
        .busy(busy), .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog and cycle count.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    // Memory model: random latency, one byte per handshake.
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (wait_n == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[mem_addr[7:0]];
                    wait_n     = $urandom_range(0, 2);
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // Count sample strobes.
    initial forever begin
        @(negedge clk);
        if (smp_valid) vcount++;
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_pos(input logic [31:0] c, input logic [31:0] s, input logic [31:0] e);
        wr(5'd0, c[31:16]); wr(5'd1, c[15:0]);
        wr(5'd2, s[31:16]); wr(5'd3, s[15:0]);
        wr(5'd4, e[31:16]); wr(5'd5, e[15:0]);
        m_cur = c; m_start = s; m_end = e;
    endtask

    task automatic set_fmt(input logic [15:0] f);
        wr(5'd6, f); m_fmt = f; m_err = 1'b0;
    endtask

    task automatic set_hist(input logic [15:0] a, input logic [15:0] b);
        wr(5'd8, a); wr(5'd9, b); m_y1 = a; m_y2 = b;
    endtask

    task automatic set_coef(input int k, input logic [15:0] v);
        wr(5'(16 + k), v); m_coef[k] = v;
    endtask

    function automatic logic [15:0] predict(input logic [3:0] n, input logic [7:0] h,
                                            input logic [15:0] y1, input logic [15:0] y2);
        int p = int'(h[6:4]);
        longint c1 = longint'($signed(m_coef[2*p]));
        longint c2 = longint'($signed(m_coef[2*p+1]));
        longint s  = 1024 + c1 * longint'($signed(y1)) + c2 * longint'($signed(y2));
        longint v  = longint'($signed(n)) * (longint'(1) << h[3:0]) + (s >>> 11);
        if (v > 32767) v = 32767;
        if (v < -32767) v = -32767;
        return v[15:0];
    endfunction

    // Reference step: returns the expected sample and advances the model.
    task automatic model_step(output logic [15:0] exp);
        logic [7:0] b;
        if (m_fmt == 16'h0000) begin
            if (m_cur[3:0] == 4'd0) begin
                m_hdr = mem[8'(m_cur[31:4] << 3)];
                m_cur = m_cur + 2;
            end
            b   = mem[8'(m_cur >> 1)];
            exp = predict(m_cur[0] ? b[3:0] : b[7:4], m_hdr, m_y1, m_y2);
            m_cur = m_cur + 1;
        end else begin
            exp   = {mem[m_cur[7:0]], mem[8'(m_cur + 1)]};
            m_cur = m_cur + 2;
        end
        if (m_fmt == 16'h0000 || m_fmt == 16'h000A) begin
            m_y2 = m_y1; m_y1 = exp;
        end else begin
            m_err = 1'b1;
        end
        if (m_cur >= m_end) m_cur = m_start;
    endtask

    task automatic get_sample(output logic [15:0] d);
        int n = 0;
        @(negedge clk); smp_req = 1'b1;
        @(negedge clk); smp_req = 1'b0;
        while (!smp_valid && n < 100) begin
            @(negedge clk); n++;
        end
        d = smp_data;
    endtask

    task automatic sample_and_check(input string req);
        logic [15:0] got, exp, hi, lo;
        get_sample(got);
        model_step(exp);
        check(req, got, exp);
        rd(5'd0, hi); rd(5'd1, lo);
        check({req, "/R9 position"}, {hi, lo}, m_cur);
        rd(5'd8, got); check({req, "/R7 yn1"}, got, m_y1);
        rd(5'd9, got); check({req, "/R7 yn2"}, got, m_y2);
    endtask

    initial begin
        logic [15:0] d;
        int v0;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 16; i++) m_coef[i] = '0;
        m_hdr = '0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        check("R1 busy", busy, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 smp_valid", smp_valid, 0);
        check("R1 smp_data", smp_data, 0);
        for (int a = 0; a < 11; a++) begin
            rd(5'(a), d); check("R1 register", d, 0);
        end
        rd(5'd21, d); check("R1 coefficient", d, 0);

        // R2: register write/readback.
        set_pos(32'h0000_0010, 32'h0000_0010, 32'h0000_0050);
        rd(5'd4, d); check("R2 end hi", d, 16'h0000);
        rd(5'd5, d); check("R2 end lo", d, 16'h0050);
        for (int k = 0; k < 16; k++) set_coef(k, 16'($signed($urandom_range(0, 8191)) - 4096));
        rd(5'd23, d); check("R2 coefficient 7", d, m_coef[7]);
        set_fmt(16'h0000);
        set_hist(16'h0100, 16'hFF00);

        // R3 R4 R5 R7 R9: random ADPCM stream across frames and a wrap.
        for (int i = 0; i < 80; i++) sample_and_check("R5 adpcm sample");
        rd(5'd7, d); check("R3 header", d, {8'h00, m_hdr});

        // R6: positive and negative saturation, directed.
        mem[8'h80] = 8'h00; mem[8'h81] = 8'h77;
        set_coef(0, 16'h7FFF); set_coef(1, 16'h7FFF);
        set_pos(32'h0000_0100, 32'h0, 32'h0000_1000);
        set_hist(16'h7FFF, 16'h7FFF);
        get_sample(d); check("R6 positive clamp", d, 16'h7FFF);
        model_step(d);
        mem[8'h88] = 8'h00; mem[8'h89] = 8'h70;
        set_coef(0, 16'h8000); set_coef(1, 16'h8000);
        set_pos(32'h0000_0110, 32'h0, 32'h0000_1000);
        set_hist(16'h7FFF, 16'h7FFF);
        get_sample(d); check("R6 negative clamp", d, 16'h8001);
        model_step(d);
        rd(5'd8, d); check("R6 yn1 clamped", d, 16'h8001);

        // R8 R9: PCM with wrap.
        set_fmt(16'h000A);
        set_pos(32'h0000_0080, 32'h0000_0080, 32'h0000_0088);
        for (int i = 0; i < 10; i++) sample_and_check("R8 pcm sample");

        // R10 R2: request and register write while busy are ignored.
        v0 = vcount;
        @(negedge clk); smp_req = 1'b1;
        @(negedge clk); smp_req = 1'b1; reg_wr_en = 1'b1; reg_addr = 5'd8; reg_wdata = 16'h1234;
        check("R10 busy after accept", busy, 1);
        @(negedge clk); smp_req = 1'b0; reg_wr_en = 1'b0;
        while (!smp_valid) @(negedge clk);
        model_step(d);
        check("R10 sample data", smp_data, d);
        repeat (12) @(negedge clk);
        check("R10 single strobe", vcount - v0, 1);
        rd(5'd8, d); check("R2 write while busy ignored", d, m_y1);
        rd(5'd1, d); check("R10 one advance", d, m_cur[15:0]);

        // R11: unknown format.
        set_fmt(16'h0005);
        set_pos(32'h0000_0040, 32'h0000_0040, 32'h0000_0044);
        for (int i = 0; i < 3; i++) sample_and_check("R11 unknown format");
        rd(5'd10, d); check("R11 status set", d, 16'h0001);
        set_fmt(16'h000A);
        rd(5'd10, d); check("R11 status cleared", d, 16'h0000);

        done = 1'b1;
        finish_run();
    end
endmodule